// File: doc/BRIEF.md
# Seconds Timer with Alarm

A memory-mapped free-running timer. A 16-bit prescale value divides a slow time base, given as a single-cycle enable pulse `slow_tick` in the system clock domain, so that a 32-bit up-counter advances once every N slow ticks. Software cannot load the counter. It can only send it back to zero with a restart command bit written together with the control word. The counter wraps freely past its all-ones value.

A 32-bit alarm value is compared with the counter. When an increment lands exactly on the alarm value, an alarm event is raised. An alarm value of all ones means "no alarm". Every increment also raises an increment event. Both events are held as status bits that are cleared by reading the status word. Each status bit is paired with an enable in the control word, and together they drive one level interrupt line.

The block sits on a simple 32-bit register bus with address, write enable, write data, read enable and combinational read data. It keeps no epoch offset and does no calendar arithmetic. Software adds its own base time.

Top module: `sec_timer_alarm`

## Requirements
- R1: After reset the words read as follows: control = 0x00008000, alarm = 0xFFFFFFFF, count = 0 and status = 0. `irq` is low.
- R2: With a non-zero prescale P in control bits [15:0], the count rises by one on every P-th `slow_tick` pulse. With P = 0 the count and the divider hold still.
- R3: A control write (offset 0x0) with bit 18 set clears both the count and the divider in that cycle. A pending increment in that cycle is dropped. Bit 18 always reads back as 0.
- R4: Writes to the count word (0x8), the status word (0xC) and any address with bits [1:0] not zero change no state.
- R5: Status bit 0 (alarm) is set by the increment that makes the count equal to the alarm word (0x4). It is never set while the alarm word holds 0xFFFFFFFF.
- R6: Status bit 1 (increment) is set by every count increment.
- R7: A read of the status word returns both bits and clears them on that clock edge. An event arriving in the same cycle as the read stays set afterwards.
- R8: `irq` is high exactly when (status bit 0 AND control bit 16) OR (status bit 1 AND control bit 17).
- R9: Control bits [17:0] and the full alarm word read back as written. Read data is valid in the same cycle that `bus_re` is high and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per slow time-base period |
| bus_addr | input | 4 | Byte address of the register word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe (status read clears status) |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt |

## Verification
Most internal faults show at the ports within one prescale period. A divider that wraps at the wrong point shows up as a count word that drifts from the tick count after P ticks. A wrong comparator shows up as status bit 0 or `irq` rising on the wrong increment, or rising while the alarm is all ones. A read-clear that swallows a coincident event shows as a status word of zero on the very next read, even though an increment was just observed. The bench mixes directed cases, such as restart, prescale zero, the disabled alarm and a read that coincides with an event, with seeded random traffic. It checks every read and the interrupt level on every cycle against a behavioural model.

// File: rtl/stm_pkg.sv
package stm_pkg;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 16;
    localparam int ADDR_W = 4;

    localparam int BIT_RESTART = PRE_W + 2;

    localparam logic [PRE_W-1:0]  PRESC_RST = PRE_W'(1) << (PRE_W - 1);
    localparam logic [DATA_W-1:0] ALARM_OFF = '1;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_ALARM  = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    // enable bits sit directly above the prescale field; status bit n pairs with enable bit n
    typedef struct packed {
        logic             ien_inc;
        logic             ien_alm;
        logic [PRE_W-1:0] presc;
    } ctrl_t;

    typedef struct packed {
        logic inc;
        logic alm;
    } status_t;

    function automatic logic addr_hit(input logic [ADDR_W-1:0] a, input reg_sel_e sel);
        return (a[1:0] == 2'b00) && (reg_sel_e'(a[ADDR_W-1:2]) == sel);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[$bits(ctrl_t)-1:0] = c;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input status_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[$bits(status_t)-1:0] = s;
        return w;
    endfunction
endpackage

// File: rtl/stm_regs.sv
module stm_regs
    import stm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [DATA_W-1:0] cnt,
    input  status_t           status,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] alarm,
    output logic              restart,
    output logic              status_rd,
    output logic [DATA_W-1:0] rdata
);
    logic wr_ctrl;
    logic wr_alarm;

    always_comb begin
        wr_ctrl   = we && addr_hit(addr, SEL_CTRL);
        wr_alarm  = we && addr_hit(addr, SEL_ALARM);
        restart   = wr_ctrl && wdata[BIT_RESTART];
        status_rd = re && addr_hit(addr, SEL_STATUS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.presc   <= PRESC_RST;
            ctrl.ien_alm <= 1'b0;
            ctrl.ien_inc <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= ALARM_OFF;
        end else if (wr_alarm) begin
            alarm <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (re && addr[1:0] == 2'b00) begin
            unique case (reg_sel_e'(addr[ADDR_W-1:2]))
                SEL_CTRL:   rdata = ctrl_word(ctrl);
                SEL_ALARM:  rdata = alarm;
                SEL_COUNT:  rdata = cnt;
                SEL_STATUS: rdata = status_word(status);
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/stm_prescaler.sv
module stm_prescaler
    import stm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_tick,
    input  logic [PRE_W-1:0] presc,
    input  logic             restart,
    output logic             inc
);
    logic [PRE_W-1:0] div_q;
    logic             run;
    logic             at_end;

    always_comb begin
        run    = presc != '0;
        // >= keeps a shrunk prescale from stranding the divider above the new limit
        at_end = run && (div_q >= presc - PRE_W'(1));
        inc    = slow_tick && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (slow_tick && run) begin
            div_q <= at_end ? '0 : div_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/stm_counter.sv
module stm_counter
    import stm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              restart,
    input  logic [DATA_W-1:0] alarm,
    input  logic              status_rd,
    output logic [DATA_W-1:0] cnt,
    output status_t           status
);
    logic [DATA_W-1:0] cnt_nxt;
    logic              inc_evt;
    logic              alm_evt;

    always_comb begin
        cnt_nxt = cnt + DATA_W'(1);
        inc_evt = inc && !restart;
        alm_evt = inc_evt && (alarm != ALARM_OFF) && (cnt_nxt == alarm);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (inc_evt) begin
            cnt <= cnt_nxt;
        end
    end

    // a new event wins over the clear-on-read in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status.alm <= (status.alm && !status_rd) || alm_evt;
            status.inc <= (status.inc && !status_rd) || inc_evt;
        end
    end
endmodule

// File: rtl/sec_timer_alarm.sv
module sec_timer_alarm
    import stm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] alarm;
    logic [DATA_W-1:0] cnt;
    status_t           status;
    logic              restart;
    logic              status_rd;
    logic              inc;

    stm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .re        (bus_re),
        .cnt       (cnt),
        .status    (status),
        .ctrl      (ctrl),
        .alarm     (alarm),
        .restart   (restart),
        .status_rd (status_rd),
        .rdata     (bus_rdata)
    );

    stm_prescaler u_pre (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .presc     (ctrl.presc),
        .restart   (restart),
        .inc       (inc)
    );

    stm_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .inc       (inc),
        .restart   (restart),
        .alarm     (alarm),
        .status_rd (status_rd),
        .cnt       (cnt),
        .status    (status)
    );

    assign irq = (status.alm && ctrl.ien_alm) || (status.inc && ctrl.ien_inc);
endmodule

// File: rtl/stm_checker.sv
module stm_checker
    import stm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              restart,
    input logic              status_rd,
    input logic [PRE_W-1:0]  presc,
    input logic              ien_alm,
    input logic              ien_inc,
    input logic [DATA_W-1:0] alarm,
    input logic [DATA_W-1:0] cnt,
    input logic              alm_st,
    input logic              inc_st,
    input logic              irq
);
    assert_stop_R2: assert property (@(posedge clk) disable iff (rst)
        (presc == '0 && !restart) |=> $stable(cnt));

    assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    assert_alarm_off_R5: assert property (@(posedge clk) disable iff (rst)
        (alarm == ALARM_OFF && !alm_st) |=> !alm_st);

    assert_inc_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt == $past(cnt) + DATA_W'(1)) |-> inc_st);

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (rst)
        status_rd |=> (!inc_st || cnt == $past(cnt) + DATA_W'(1)));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (alm_st || inc_st));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (!ien_alm && !ien_inc) |-> !irq);
endmodule

bind sec_timer_alarm stm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .status_rd (status_rd),
    .presc     (ctrl.presc),
    .ien_alm   (ctrl.ien_alm),
    .ien_inc   (ctrl.ien_inc),
    .alarm     (alarm),
    .cnt       (cnt),
    .alm_st    (status.alm),
    .inc_st    (status.inc),
    .irq       (irq)
);

// File: tb/sec_timer_alarm_tb.sv
module sec_timer_alarm_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    logic [31:0] m_cnt, m_div, m_presc, m_alarm;
    logic        m_ena, m_eni, m_sa, m_si;

    always #5 clk = ~clk;

    sec_timer_alarm u_dut (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[3:2])
            2'd0: return {14'h0, m_eni, m_ena, m_presc[15:0]};
            2'd1: return m_alarm;
            2'd2: return m_cnt;
            default: return {30'h0, m_si, m_sa};
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_div = 0; m_presc = 32'h8000; m_alarm = 32'hFFFF_FFFF;
        m_ena = 0; m_eni = 0; m_sa = 0; m_si = 0;
    endtask

    task automatic model_step(input logic tk, input logic we, input logic re,
                              input logic [3:0] a, input logic [31:0] wd);
        logic rs, inc, ev_i, ev_a, rd;
        rs  = we && a == 4'h0 && wd[18];
        inc = tk && m_presc != 0 && (m_div + 1 >= m_presc);
        ev_i = inc && !rs;
        ev_a = ev_i && m_alarm != 32'hFFFF_FFFF && (m_cnt + 1) == m_alarm;
        rd  = re && a == 4'hC;
        if (rs) begin m_cnt = 0; m_div = 0; end
        else if (tk && m_presc != 0) begin
            if (inc) begin m_div = 0; m_cnt = m_cnt + 1; end
            else m_div = m_div + 1;
        end
        m_sa = (m_sa && !rd) || ev_a;
        m_si = (m_si && !rd) || ev_i;
        if (we && a == 4'h0) begin m_presc = {16'h0, wd[15:0]}; m_ena = wd[16]; m_eni = wd[17]; end
        if (we && a == 4'h4) m_alarm = wd;
    endtask

    // one bus cycle: drive, check read data and irq against model, advance model
    task automatic cyc(input logic tk, input logic we, input logic re,
                       input logic [3:0] a, input logic [31:0] wd, input string tag);
        @(negedge clk);
        slow_tick = tk; bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd;
        #1;
        if (re) check(bus_rdata, model_read(a), tag);
        check({31'h0, irq}, {31'h0, (m_sa && m_ena) || (m_si && m_eni)}, "R8 irq level");
        model_step(tk, we, re, a, wd);
    endtask

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) cyc(tk, 0, 0, 4'h0, 32'h0, "idle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset values
        cyc(0, 0, 1, 4'h0, 0, "R1 ctrl reset");
        check(bus_rdata, 32'h0000_8000, "R1 ctrl reset literal");
        cyc(0, 0, 1, 4'h4, 0, "R1 alarm reset");
        check(bus_rdata, 32'hFFFF_FFFF, "R1 alarm reset literal");
        cyc(0, 0, 1, 4'h8, 0, "R1 count reset");
        cyc(0, 0, 1, 4'hC, 0, "R1 status reset");
        check({31'h0, irq}, 32'h0, "R1 irq reset");

        // R2 prescale 3: six ticks -> count 2; R9 readback
        cyc(0, 1, 0, 4'h0, 32'h0000_0003, "R9 write ctrl");
        cyc(0, 0, 1, 4'h0, 0, "R9 ctrl readback");
        idle(6, 1);
        cyc(0, 0, 1, 4'h8, 0, "R2 count after six ticks at prescale 3");
        check(bus_rdata, 32'd2, "R2 count literal");

        // R3 restart, bit 18 reads 0
        cyc(0, 1, 0, 4'h0, 32'h0004_0001, "R3 restart");
        cyc(0, 0, 1, 4'h8, 0, "R3 count cleared");
        check(bus_rdata, 32'd0, "R3 count literal");
        cyc(0, 0, 1, 4'h0, 0, "R3 restart bit reads zero");
        check(bus_rdata, 32'h0000_0001, "R3 ctrl literal");

        // R4 ignored writes
        idle(4, 1);
        cyc(0, 1, 0, 4'h8, 32'h1234_5678, "R4 write count");
        cyc(0, 1, 0, 4'h5, 32'h0000_0000, "R4 misaligned write");
        cyc(0, 1, 0, 4'h2, 32'h0004_0000, "R4 misaligned restart");
        cyc(0, 0, 1, 4'h8, 0, "R4 count unchanged");
        check(bus_rdata, 32'd4, "R4 count literal");
        cyc(0, 0, 1, 4'h4, 0, "R4 alarm unchanged");
        cyc(0, 1, 0, 4'hC, 32'h3, "R4 write status");
        cyc(0, 0, 1, 4'hC, 0, "R4 status after write (R6 inc set)");
        check(bus_rdata, 32'h2, "R6 inc flag literal");

        // R5 alarm at 5
        cyc(0, 1, 0, 4'h4, 32'd5, "R9 write alarm");
        cyc(0, 1, 0, 4'h0, 32'h0004_0001, "R3 restart");
        cyc(0, 0, 1, 4'hC, 0, "R7 clear");
        idle(4, 1);
        cyc(0, 0, 1, 4'hC, 0, "R5 alarm not yet");
        check(bus_rdata, 32'h2, "R5 alarm literal before");
        idle(1, 1);
        cyc(0, 0, 1, 4'hC, 0, "R5 alarm hit");
        check(bus_rdata, 32'h3, "R5 alarm literal hit");
        cyc(0, 0, 1, 4'hC, 0, "R7 cleared by read");
        check(bus_rdata, 32'h0, "R7 clear literal");

        // R5 disabled alarm value
        cyc(0, 1, 0, 4'h4, 32'hFFFF_FFFF, "R5 disable");
        idle(10, 1);
        cyc(0, 0, 1, 4'hC, 0, "R5 no alarm when all ones");
        check(bus_rdata & 32'h1, 32'h0, "R5 alarm bit literal");

        // R8 irq with enables
        cyc(0, 1, 0, 4'h0, 32'h0002_0001, "R8 enable inc irq");
        idle(1, 1);
        cyc(0, 0, 0, 4'h0, 0, "R8 irq high");
        check({31'h0, irq}, 32'h1, "R8 irq literal");
        cyc(0, 0, 1, 4'hC, 0, "R7 read clears");
        cyc(0, 0, 0, 4'h0, 0, "R8 irq low after read");
        check({31'h0, irq}, 32'h0, "R8 irq low literal");

        // R7 read coincident with increment keeps the new event
        cyc(1, 0, 1, 4'hC, 0, "R7 read with tick");
        cyc(0, 0, 1, 4'hC, 0, "R7 event survives read");
        check(bus_rdata, 32'h2, "R7 survive literal");

        // R2 prescale zero stops
        cyc(0, 1, 0, 4'h0, 32'h0, "R2 prescale zero");
        cyc(0, 0, 1, 4'h8, 0, "R2 count before");
        idle(8, 1);
        cyc(0, 0, 1, 4'h8, 0, "R2 count held at prescale zero");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r, wd;
            logic [3:0]  a;
            r  = $urandom;
            a  = {r[3:2], (r[9:7] == 3'd0) ? r[1:0] : 2'b00};
            wd = $urandom;
            if (a == 4'h0) wd = {13'h0, (r[12:10] == 3'd0), wd[17:16], 13'h0, wd[2:0]};
            if (a == 4'h4 && r[13]) wd = m_cnt + {28'h0, wd[3:0]};
            cyc(r[4], r[6:5] == 2'b00, r[14], a, wd, "R2-random model");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule